// File: doc/BRIEF.md
# Serial Two-Wire Register-Access Slave

This block lets an external master on an I2C bus read and write a bank of 16-bit registers. It watches the clock and data lines through synchronizers clocked by the system clock and finds start and stop conditions. After a start it compares the first byte against its 7-bit bus address: a fixed upper part and two low bits taken from strap inputs. When the address matches it acknowledges. It never drives the clock line and never begins a transfer of its own.

In a write transaction the first two data bytes load a 10-bit register pointer. After that, each pair of bytes is written as one 16-bit word to the register the pointer selects, and the pointer then steps forward. In a read transaction the slave sends the selected register as two bytes and steps the pointer after each complete word. It keeps sending until the master answers a byte with a not-acknowledge. A stop condition always puts the slave back to idle and clears the pointer to zero. A repeated start keeps the pointer, so the usual way to read is: write the pointer, issue a repeated start, then read.

The register storage sits outside the block. The slave presents the pointer as the register address, reads the word through a combinational read port, and writes through a one-cycle write strobe.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte (it pulls SDA low during the ninth clock) when bits 7:1 equal {01011, strap_a1, strap_a0}. Bit 0 of that byte selects the direction: 0 is a master write, 1 is a master read.
- R2: When the address does not match, the slave does not drive SDA and issues no register write until the next start condition.
- R3: In a write transaction the slave acknowledges every byte. The first data byte supplies pointer bits 9:8 in its bits 1:0, and the second byte supplies pointer bits 7:0.
- R4: After the two pointer bytes, each following byte pair (high byte first) gives one single-cycle reg_wr_en pulse. The pulse carries reg_addr equal to the pointer and reg_wr_data equal to {high, low}.
- R5: In a read transaction the slave sends the word at the pointer as the high byte then the low byte, MSB first. It releases SDA during each acknowledge bit driven by the master.
- R6: The pointer advances by one, modulo 1024, after each complete 16-bit word, in reads and in writes alike.
- R7: A master not-acknowledge ends the read. The slave then leaves SDA released until the next start or stop.
- R8: A stop condition returns the slave to idle and sets the pointer (reg_addr) to 0.
- R9: A repeated start (a start with no stop before it) keeps the pointer value.
- R10: After reset sda_oe and reg_wr_en are 0. The slave changes sda_oe only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| strap_a1 | input | 1 | Bus address bit 1 strap |
| strap_a0 | input | 1 | Bus address bit 0 strap |
| reg_addr | output | 10 | Register address (current pointer) |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 16 | Register write word |
| reg_rd_data | input | 16 | Register read word for reg_addr |

## Verification
The hardest case to reach from the ports is a read that starts somewhere other than register 0. A stop always clears the pointer, so the only way to get there is a write of the pointer bytes followed by a repeated start with no stop between them. The stimulus builds that sequence directly. It also uses the same sequence in random transactions with random pointers, including pointers near the top of the range so that word transfers wrap the pointer to 0. Separate directed cases cover an address that fails to match because of a strap bit, a not-acknowledge after a single byte, and a change of the strap inputs.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int BYTE_W  = 8;
    localparam int DATA_W  = 2 * BYTE_W;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [4:0] DEV_ADDR_HI = 5'b01011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK
    } proto_st_e;

    typedef enum logic [1:0] {
        WB_PTR_HI,
        WB_PTR_LO,
        WB_DAT_HI,
        WB_DAT_LO
    } wbyte_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic a1, input logic a0);
        return b[BYTE_W-1:1] == {DEV_ADDR_HI, a1, a0};
    endfunction

endpackage

// File: rtl/i2c_rb_linemon.sv
module i2c_rb_linemon
    import i2c_rb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    localparam int NLINES = 2;
    localparam int IDX_SCL = 1;
    localparam int IDX_SDA = 0;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    always_comb begin
        ev.scl   = synced[IDX_SCL];
        ev.sda   = synced[IDX_SDA];
        ev.rise  = synced[IDX_SCL] & ~prev[IDX_SCL];
        ev.fall  = ~synced[IDX_SCL] & prev[IDX_SCL];
        ev.start = synced[IDX_SCL] & prev[IDX_SCL] & prev[IDX_SDA] & ~synced[IDX_SDA];
        ev.stop  = synced[IDX_SCL] & prev[IDX_SCL] & ~prev[IDX_SDA] & synced[IDX_SDA];
    end

endmodule

// File: rtl/i2c_rb_proto.sv
module i2c_rb_proto
    import i2c_rb_pkg::*;
#(
    parameter int PTR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic              strap_a1,
    input  logic              strap_a0,
    input  logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    proto_st_e          st;
    wbyte_e             wsel;
    logic [CNT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  tx;
    logic [BYTE_W-1:0]  lo_q;
    logic [BYTE_W-1:0]  ptr_hi_q;
    logic [BYTE_W-1:0]  dat_hi_q;
    logic [PTR_W-1:0]   ptr;
    logic               rw_q;
    logic               rd_lo;
    logic               rack_ok;
    logic               byte_done;

    assign byte_done = ev.fall && (bitcnt == CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            wsel     <= WB_PTR_HI;
            bitcnt   <= '0;
            shreg    <= '0;
            tx       <= '1;
            lo_q     <= '0;
            ptr_hi_q <= '0;
            dat_hi_q <= '0;
            ptr      <= '0;
            rw_q     <= 1'b0;
            rd_lo    <= 1'b0;
            rack_ok  <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            ptr    <= '0;
            bitcnt <= '0;
        end else if (ev.start) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (ev.rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + CNT_W'(1);
                    end else if (byte_done) begin
                        if (addr_hit(shreg, strap_a1, strap_a0)) begin
                            st   <= ST_ACK_A;
                            rw_q <= shreg[0];
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_A: begin
                    if (ev.fall) begin
                        bitcnt <= '0;
                        if (rw_q) begin
                            st    <= ST_RD;
                            tx    <= rd_data[DATA_W-1:BYTE_W];
                            lo_q  <= rd_data[BYTE_W-1:0];
                            rd_lo <= 1'b0;
                        end else begin
                            st   <= ST_WR;
                            wsel <= WB_PTR_HI;
                        end
                    end
                end
                ST_WR: begin
                    if (ev.rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + CNT_W'(1);
                    end else if (byte_done) begin
                        st <= ST_WACK;
                        unique case (wsel)
                            WB_PTR_HI: begin
                                ptr_hi_q <= shreg;
                                wsel     <= WB_PTR_LO;
                            end
                            WB_PTR_LO: begin
                                ptr  <= PTR_W'({ptr_hi_q, shreg});
                                wsel <= WB_DAT_HI;
                            end
                            WB_DAT_HI: begin
                                dat_hi_q <= shreg;
                                wsel     <= WB_DAT_LO;
                            end
                            WB_DAT_LO: begin
                                ptr  <= ptr + PTR_W'(1);
                                wsel <= WB_DAT_HI;
                            end
                            default: wsel <= WB_PTR_HI;
                        endcase
                    end
                end
                ST_WACK: begin
                    if (ev.fall) begin
                        st     <= ST_WR;
                        bitcnt <= '0;
                    end
                end
                ST_RD: begin
                    if (ev.fall) begin
                        if (bitcnt == CNT_LAST) begin
                            st     <= ST_RACK;
                            bitcnt <= '0;
                            if (rd_lo) ptr <= ptr + PTR_W'(1);
                        end else begin
                            tx     <= {tx[BYTE_W-2:0], 1'b1};
                            bitcnt <= bitcnt + CNT_W'(1);
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.rise) begin
                        rack_ok <= ~ev.sda;
                    end else if (ev.fall) begin
                        if (rack_ok) begin
                            st <= ST_RD;
                            if (rd_lo) begin
                                tx    <= rd_data[DATA_W-1:BYTE_W];
                                lo_q  <= rd_data[BYTE_W-1:0];
                                rd_lo <= 1'b0;
                            end else begin
                                tx    <= lo_q;
                                rd_lo <= 1'b1;
                            end
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign reg_addr    = ptr;
    assign reg_wr_en   = (st == ST_WR) && byte_done && (wsel == WB_DAT_LO);
    assign reg_wr_data = {dat_hi_q, shreg};
    assign sda_oe      = (st == ST_ACK_A) || (st == ST_WACK) || ((st == ST_RD) && !tx[BYTE_W-1]);

    AST_STOP_CLEARS_PTR: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (reg_addr == '0)); // R8
    AST_PTR_STEP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> (reg_addr == $past(reg_addr) + PTR_W'(1))); // R6
    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en); // R4
    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !ev.scl); // R10
    AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD) |-> !reg_wr_en); // R2

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter int PTR_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              strap_a1,
    input  logic              strap_a0,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    input  logic [DATA_W-1:0] reg_rd_data
);
    line_ev_t ev;

    i2c_rb_linemon #(.STAGES(SYNC_STAGES)) u_linemon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_rb_proto #(.PTR_W(PTR_W)) u_proto (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .strap_a1    (strap_a1),
        .strap_a0    (strap_a0),
        .rd_data     (reg_rd_data),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .sda_oe      (sda_oe)
    );

endmodule

// File: tb/i2c_regbank_slave_tb_top.sv
module i2c_regbank_slave_tb_top;
    localparam int PW    = 10;
    localparam int DEPTH = 1 << PW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic a1 = 1'b1, a0 = 1'b0;
    logic sda_oe, reg_wr_en;
    logic [PW-1:0] reg_addr;
    logic [15:0] reg_wr_data, reg_rd_data;
    wire  sda_line = sda_m & ~sda_oe;

    logic [15:0] mem [DEPTH];
    logic [15:0] exp_mem [DEPTH];
    int wr_count = 0, drive_viol = 0, checks = 0, errors = 0, exp_ptr = 0;
    logic oe_prev = 1'b0, scl_prev = 1'b1;

    assign reg_rd_data = mem[reg_addr];

    i2c_regbank_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_a1(a1), .strap_a0(a0), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
    );

    always @(posedge clk) if (reg_wr_en) begin
        mem[reg_addr] <= reg_wr_data;
        wr_count <= wr_count + 1;
    end

    // R10: data drive may only change while SCL is low
    always @(negedge clk) begin
        if (!rst && scl_m && scl_prev && (sda_oe != oe_prev)) drive_viol++;
        oe_prev  <= sda_oe;
        scl_prev <= scl_m;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b, output logic seen);
        tick(2); sda_m = b; tick(2); scl_m = 1'b1; tick(4);
        seen = sda_line; tick(4); scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        tick(2); sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(4);
        b = sda_line; tick(4); scl_m = 1'b0;
    endtask

    task automatic start_c();
        if (!scl_m) begin
            tick(2); sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(4);
        end
        sda_m = 1'b0; tick(4); scl_m = 1'b0;
    endtask

    task automatic stop_c();
        tick(2); sda_m = 1'b0; tick(2); scl_m = 1'b1; tick(4); sda_m = 1'b1; tick(6);
        exp_ptr = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s, a;
        for (int i = 7; i >= 0; i--) bit_out(b[i], s);
        bit_in(a);
        acked = !a;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d, output logic seen);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(nack, seen);
    endtask

    function automatic logic [7:0] dev_byte(input logic s1, input logic s0, input logic rd);
        return {5'b01011, s1, s0, rd};
    endfunction

    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 40503) ^ 16'h5A5A;
    endfunction

    // write pointer then n words; optional stop
    task automatic wr_txn(input int p, input int n, input bit do_stop);
        logic ak;
        logic [15:0] d;
        start_c();
        send_byte(dev_byte(a1, a0, 1'b0), ak);
        chk(ak, "R1 write address ack", ak, 1);
        send_byte({6'b0, 2'(p >> 8)}, ak);
        chk(ak, "R3 pointer high ack", ak, 1);
        send_byte(8'(p), ak);
        chk(ak, "R3 pointer low ack", ak, 1);
        exp_ptr = p % DEPTH;
        for (int i = 0; i < n; i++) begin
            d = 16'($urandom);
            send_byte(d[15:8], ak);
            chk(ak, "R3 data high ack", ak, 1);
            send_byte(d[7:0], ak);
            chk(ak, "R3 data low ack", ak, 1);
            exp_mem[exp_ptr] = d;
            chk(mem[exp_ptr] == d, "R4 register write", mem[exp_ptr], d);
            exp_ptr = (exp_ptr + 1) % DEPTH;
        end
        if (do_stop) stop_c();
    endtask

    // read n whole words from the expected pointer, last low byte NACKed
    task automatic rd_txn(input int n, input bit do_stop);
        logic ak, seen;
        logic [7:0] hi, lo;
        start_c();
        send_byte(dev_byte(a1, a0, 1'b1), ak);
        chk(ak, "R1 read address ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(1'b0, hi, seen);
            recv_byte(i == n - 1, lo, seen);
            chk({hi, lo} == exp_mem[exp_ptr], "R5 R6 read word", {hi, lo}, exp_mem[exp_ptr]);
            exp_ptr = (exp_ptr + 1) % DEPTH;
        end
        chk(seen == 1'b1, "R5 released during master ack", seen, 1);
        if (do_stop) stop_c();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic ak, b;
        logic [7:0] dd;
        int w0;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = init_word(i);
            exp_mem[i] = init_word(i);
        end
        tick(5);
        rst = 1'b0;
        tick(2);
        chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
        chk(reg_wr_en == 1'b0, "R10 reset reg_wr_en", reg_wr_en, 0);
        chk(reg_addr == '0, "R8 reset pointer", reg_addr, 0);

        // wrap at top of range, then re-point and read back via repeated start
        wr_txn(10'h3FE, 3, 1'b0);
        chk(exp_ptr == 1, "R6 write pointer wrap", exp_ptr, 1);
        wr_txn(10'h3FE, 0, 1'b0);
        rd_txn(3, 1'b1);
        chk(reg_addr == '0, "R8 stop clears pointer", reg_addr, 0);

        // R8: fresh transaction after stop reads from register 0
        rd_txn(2, 1'b1);

        // R9: repeated start keeps pointer
        wr_txn(10'h100, 2, 1'b0);
        rd_txn(1, 1'b1);

        // R2: strap bit mismatch, then upper bits mismatch
        w0 = wr_count;
        start_c();
        send_byte(dev_byte(a1, ~a0, 1'b0), ak);
        chk(!ak, "R2 strap mismatch no ack", ak, 0);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'hA5, ak);
            chk(!ak, "R2 no ack after mismatch", ak, 0);
        end
        start_c();
        send_byte(8'b0111_1000 | {6'b0, a1, a0} << 1, ak);
        chk(!ak, "R2 upper mismatch no ack", ak, 0);
        send_byte(8'h00, ak);
        send_byte(8'h00, ak);
        stop_c();
        chk(wr_count == w0, "R2 no register writes", wr_count, w0);

        // R7: NACK after a single byte releases the line
        start_c();
        send_byte(dev_byte(a1, a0, 1'b1), ak);
        chk(ak, "R1 read address ack", ak, 1);
        recv_byte(1'b1, dd, b);
        chk(dd == exp_mem[0][15:8], "R5 high byte first", dd, exp_mem[0][15:8]);
        for (int i = 0; i < 9; i++) begin
            bit_in(b);
            chk(b == 1'b1, "R7 line released after nack", b, 1);
        end
        stop_c();

        // R1: new straps take effect, old address ignored
        a1 = 1'b0; a0 = 1'b1;
        tick(4);
        wr_txn(10'h2A5, 1, 1'b1);
        start_c();
        send_byte(dev_byte(1'b1, 1'b0, 1'b0), ak);
        chk(!ak, "R1 old strap address ignored", ak, 0);
        stop_c();

        // random transactions
        for (int t = 0; t < 16; t++) begin
            int p, n;
            p = (t % 4 == 0) ? (DEPTH - 1 - int'($urandom % 2)) : int'($urandom % DEPTH);
            n = 1 + int'($urandom % 3);
            if ($urandom % 2) begin
                wr_txn(p, n, 1'b1);
                wr_txn(p, 0, 1'b0);
            end else begin
                wr_txn(p, n, 1'b0);
                wr_txn(p, 0, 1'b0);
            end
            rd_txn(n, 1'b1);
        end

        chk(drive_viol == 0, "R10 drive changes only with SCL low", drive_viol, 0);
        finish_run();
    end

endmodule